// File: doc/BRIEF.md
# Self-Sequencing Memory Command Replayer

The block holds two memories. A small program memory stores a looping list of command words. While clock enable is high, one word is fetched from it on every clock edge. The word fetched on one edge drives the command and address inputs of a second memory, the sample store, on the next running edge. Nothing between the two memories decides what happens next, so capture proceeds at full clock rate with no controller involved.

A command word that encodes a write stores the 32-bit input sample at the address the word carries. Every other encoding does nothing. Each word also carries a small waveform field, which is presented on an output pin while that word is the current command. A pattern can therefore be played out alongside capture.

A slow host works the block only through clock enable. With enable low, the loop is frozen in place. While frozen, the host may:
- rewrite program entries,
- set the index of the last entry of the loop,
- read stored samples back.

Raising enable resumes the loop exactly where it stopped. All host inputs are sampled on the block clock.

Top module: `cmd_replayer`

## Requirements
- R1: After reset, `wave_out` is 0, `rd_data` is 0, the loop pointer is at entry 0 and the current command is a deselect (control nibble 4'b1111), so the first running edge stores nothing.
- R2: A command word is {wave[WAVE_W-1:0], cs_n, ras_n, cas_n, we_n, addr[ADDR_W-1:0]}, with the control nibble at bits [ADDR_W+3:ADDR_W]. The nibble 4'b0100 means write. A write word fetched on one running edge stores `sample_in`, as present at the next running edge, into sample address `addr`.
- R3: Every control nibble other than 4'b0100 leaves the sample store unchanged. This includes read 4'b0101, activate 4'b0011 and deselected 4'b1100.
- R4: On each running edge the pointer advances by one. After fetching entry `last`, or any entry with an index above `last`, it returns to entry 0. With `last` = 0, entry 0 repeats every cycle.
- R5: While `cke` is low, no sample is stored and the pointer and current command hold. When `cke` rises again, the held command acts on the first running edge.
- R6: `wave_out` shows the wave field of the most recently fetched program word.
- R7: On an edge with `cke` low, `rd_data` takes the sample stored at `rd_addr`. While `cke` is high, `rd_data` holds.
- R8: Program writes (`prog_we`) and loop-length writes (`len_we`) take effect only on edges with `cke` low. On edges with `cke` high they are ignored.
- R9: All 32 bits of `sample_in` are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable: high runs the loop, low freezes it and opens the host port |
| prog_we | input | 1 | Write strobe for one program entry |
| prog_addr | input | PAW | Program entry index |
| prog_wdata | input | CW | Program word {wave, cs_n, ras_n, cas_n, we_n, addr} |
| len_we | input | 1 | Write strobe for the last-entry index |
| len_wdata | input | PAW | Index of the last loop entry |
| sample_in | input | SAMPLE_W | Input sample captured by write commands |
| rd_addr | input | ADDR_W | Sample readback address |
| rd_data | output | SAMPLE_W | Registered readback data |
| wave_out | output | WAVE_W | Wave field of the current command |

## Verification
The hardest situation to create is the handover at a pause. When `cke` falls, a fetched command is left pending. When `cke` rises again, that command must act with the sample present at the resume edge, and the pointer must not skip or repeat an entry.

The stimulus creates this handover in several ways:
- long pauses;
- `cke` toggled every cycle;
- a loop length shrunk below the frozen pointer;
- host writes attempted while the loop is running.

A behavioural model tracks the program, the pointer and every store. It compares `wave_out` and readback on every cycle. Afterwards, readback shows which addresses were overwritten and which kept their earlier contents.

// File: rtl/cmd_replayer.sv
module cmd_replayer #(
  parameter int ADDR_W     = 8,
  parameter int PROG_DEPTH = 16,
  parameter int WAVE_W     = 8,
  parameter int SAMPLE_W   = 32,
  localparam int PAW = $clog2(PROG_DEPTH),
  localparam int CW  = WAVE_W + 4 + ADDR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cke,
  input  logic                prog_we,
  input  logic [PAW-1:0]      prog_addr,
  input  logic [CW-1:0]       prog_wdata,
  input  logic                len_we,
  input  logic [PAW-1:0]      len_wdata,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [SAMPLE_W-1:0] rd_data,
  output logic [WAVE_W-1:0]   wave_out
);
  localparam logic [3:0] CTL_WRITE = 4'b0100;
  localparam logic [CW-1:0] CMD_IDLE = {{WAVE_W{1'b0}}, 4'b1111, {ADDR_W{1'b0}}};

  logic [CW-1:0]       prog_mem [PROG_DEPTH];
  logic [SAMPLE_W-1:0] smem     [2**ADDR_W];
  logic [PAW-1:0]      ptr, last;
  logic [CW-1:0]       cmd_q;

  wire [3:0]        ctl    = cmd_q[ADDR_W +: 4];
  wire [ADDR_W-1:0] wa     = cmd_q[ADDR_W-1:0];
  wire              do_wr  = cke && (ctl == CTL_WRITE);
  wire              at_end = ptr >= last;
  wire [PAW-1:0]    nxt    = at_end ? '0 : PAW'(ptr + 1'b1);

  assign wave_out = cmd_q[CW-1 -: WAVE_W];

  always_ff @(posedge clk)
    if (!cke && prog_we) prog_mem[prog_addr] <= prog_wdata;

  always_ff @(posedge clk)
    if (do_wr) smem[wa] <= sample_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ptr     <= '0;
      last    <= '0;
      cmd_q   <= CMD_IDLE;
      rd_data <= '0;
    end else if (cke) begin
      cmd_q <= prog_mem[ptr];
      ptr   <= nxt;
    end else begin
      if (len_we) last <= len_wdata;
      rd_data <= smem[rd_addr];
    end

  p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(ptr) && $stable(cmd_q));
  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cke && (ptr < last) |=> ptr == $past(ptr) + 1'b1);
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cke && (ptr >= last) |=> ptr == '0);
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> $stable(rd_data));
  p_len_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> $stable(last));
  p_wave_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(wave_out));
endmodule

// File: tb/cmd_replayer_test.sv
module cmd_replayer_test;
  localparam int AW = 8, PD = 16, WW = 8, SW = 32, PAW = 4, CW = WW + 4 + AW;

  logic clk = 0, rst_n = 0, cke = 0, prog_we = 0, len_we = 0;
  logic [PAW-1:0] prog_addr = 0, len_wdata = 0;
  logic [CW-1:0]  prog_wdata = 0;
  logic [SW-1:0]  sample_in = 32'h1234_5678;
  logic [AW-1:0]  rd_addr = 0;
  logic [SW-1:0]  rd_data;
  logic [WW-1:0]  wave_out;

  cmd_replayer uut (.clk, .rst_n, .cke, .prog_we, .prog_addr, .prog_wdata,
                    .len_we, .len_wdata, .sample_in, .rd_addr, .rd_data, .wave_out);

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  string tag = "R1";

  logic [CW-1:0] pm [PD];
  logic [SW-1:0] sm [2**AW];
  bit            sv [2**AW];
  int            ptr_m = 0, last_m = 0;
  logic [CW-1:0] pend = {8'h00, 4'hF, 8'h00};
  logic [SW-1:0] rd_m = 0;
  bit            rd_ok = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      ptr_m = 0; last_m = 0; pend = {8'h00, 4'hF, 8'h00}; rd_m = 0; rd_ok = 1;
    end else if (cke) begin
      if (pend[AW +: 4] == 4'b0100) begin
        sm[pend[AW-1:0]] = sample_in; sv[pend[AW-1:0]] = 1;
      end
      pend  = pm[ptr_m];
      ptr_m = (ptr_m >= last_m) ? 0 : ptr_m + 1;
    end else begin
      if (prog_we) pm[prog_addr] = prog_wdata;
      if (len_we) last_m = int'(len_wdata);
      rd_m  = sm[rd_addr];
      rd_ok = sv[rd_addr];
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    vectors++;
    if (wave_out !== pend[CW-1 -: WW]) begin
      miscompares++;
      $display("FAIL %s wave_out actual %h expected %h", tag, wave_out, pend[CW-1 -: WW]);
    end
    if (rd_ok) begin
      vectors++;
      if (rd_data !== rd_m) begin
        miscompares++;
        $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, rd_m);
      end
    end
    sample_in <= sample_in * 32'h0019660D + 32'h3C6EF35F;
  end

  function automatic logic [CW-1:0] mk(input logic [7:0] w, input logic [3:0] c, input logic [7:0] a);
    return {w, c, a};
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_prog(input int i, input logic [CW-1:0] d);
    prog_addr <= PAW'(i); prog_wdata <= d; prog_we <= 1;
    cyc(1); prog_we <= 0;
  endtask

  task automatic set_last(input int l);
    len_wdata <= PAW'(l); len_we <= 1;
    cyc(1); len_we <= 0;
  endtask

  initial begin
    cyc(3);
    rst_n <= 1;
    tag = "R1"; cyc(3);
    for (int i = 0; i < PD; i++) wr_prog(i, mk(8'(8'h40 + i), 4'hF, 8'(i)));
    wr_prog(0, mk(8'h01, 4'b0100, 8'd10));
    wr_prog(1, mk(8'h02, 4'b0100, 8'd11));
    wr_prog(2, mk(8'h03, 4'b0100, 8'd12));
    set_last(2);
    tag = "R4"; cke <= 1; cyc(7); cke <= 0; cyc(1);
    for (int i = 0; i < 6; i++) wr_prog(i, mk(8'(8'h10 + i), 4'b0100, 8'(i)));
    wr_prog(6, mk(8'h20, 4'b0101, 8'd10));
    wr_prog(7, mk(8'h21, 4'b0011, 8'd11));
    wr_prog(8, mk(8'h22, 4'b1100, 8'd12));
    set_last(8);
    tag = "R6"; cke <= 1; cyc(25);
    tag = "R8";
    prog_addr <= 2; prog_wdata <= mk(8'hFF, 4'b0100, 8'd50); prog_we <= 1;
    len_wdata <= 3; len_we <= 1;
    cyc(3); prog_we <= 0; len_we <= 0; cyc(12);
    tag = "R5"; cke <= 0; cyc(6); cke <= 1; cyc(12);
    for (int i = 0; i < 12; i++) begin cke <= ~cke; cyc(1); end
    cke <= 0; cyc(1);
    tag = "R2"; for (int i = 0; i < 6; i++) begin rd_addr <= 8'(i); cyc(2); end
    tag = "R3"; for (int i = 10; i < 13; i++) begin rd_addr <= 8'(i); cyc(2); end
    tag = "R8"; rd_addr <= 8'd50; cyc(2);
    tag = "R7"; cke <= 1;
    for (int i = 0; i < 6; i++) begin rd_addr <= 8'(i); cyc(1); end
    cke <= 0; cyc(2);
    tag = "R4"; set_last(0); cke <= 1; cyc(6); cke <= 0; cyc(1);
    set_last(15); cke <= 1; cyc(20); cke <= 0; cyc(1);
    tag = "R9"; for (int i = 0; i < 6; i++) begin rd_addr <= 8'(i); cyc(2); end
    tag = "R3"; for (int i = 10; i < 13; i++) begin rd_addr <= 8'(i); cyc(2); end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired in %s", tag);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule